// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block accepts one operation request from a host and expands it into the series of bus write and read cycles that a parallel NOR flash needs for that operation. The host gives an operation code, a user address, a data word, a bank number and a bus-width flag, then pulses a start strobe. The block raises `busy` while it walks through the cycles and pulses `done` once the final cycle has been accepted by the memory port.

Each bus cycle goes out through a request/acknowledge port. The block holds the request, address, write data and write enable steady until the memory side acknowledges. Command cycles go to fixed command offsets. These offsets are doubled when the bus is 16 bits wide, then added to the base address of the selected bank. Words read back during identifier and query operations are stored in four output slots.

Top module: `flashCmdSeq`

## Requirements
- R1: Read-ID (opcode 0), program (opcode 2), sector erase (opcode 3) and chip erase (opcode 4) each start with two writes: 0x55 at command offset 0x2AA, preceded by 0xAA at command offset 0x555.
- R2: Read-ID then writes 0x90 at offset 0x555 and reads offsets 0x00, 0x01, 0x0E, 0x0F in that order, storing them in rdBack slots 0 to 3 (slot k at bits k*DATA_W and up).
- R3: Program then writes 0xA0 at offset 0x555, followed by reqData written at reqAddr, which is used as an absolute bus address.
- R4: Sector erase then writes 0x80 at 0x555, 0xAA at 0x555 and 0x55 at 0x2AA, and ends by writing 0x30 at reqAddr.
- R5: Chip erase issues the same first five writes as sector erase and ends with 0x10 at offset 0x555.
- R6: CFI query (opcode 5) writes 0x98 at offset 0x055 with no prefix, then reads offsets 0x10 to 0x13 into rdBack slots 0 to 3.
- R7: Return-to-read (opcode 1) is one write of 0xF0 to the bank base address, with no prefix.
- R8: The bank base is bankSel shifted left by BANK_SHIFT. A command address is that base plus the offset, with the offset shifted left by one when busWide is 1. bankSel and busWide are sampled when the start is accepted.
- R9: An accepted start raises busy in the next cycle. A start while busy, or one with opcode 6 or 7, is ignored: the running sequence does not change, busy does not rise, and rejected pulses in the next cycle.
- R10: done is high for exactly one cycle, in the cycle after the last cycle's acknowledge, and busy is low in that same cycle.
- R11: memReq stays high with memAddr, memWdata and memWe unchanged until memAck. memWe is 1 for writes and 0 for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqOp | input | 3 | Operation code |
| reqAddr | input | ADDR_W | User address for program and sector erase |
| reqData | input | DATA_W | Data word to program |
| bankSel | input | 2 | Bank number |
| busWide | input | 1 | 1 selects a 16-bit bus (command offsets doubled) |
| reqStart | input | 1 | Start strobe |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |
| rejected | output | 1 | One-cycle pulse for a refused start |
| memReq | output | 1 | Bus cycle request |
| memWe | output | 1 | 1 = write cycle, 0 = read cycle |
| memAddr | output | ADDR_W | Bus cycle address |
| memWdata | output | DATA_W | Bus write data |
| memAck | input | 1 | Bus cycle acknowledge |
| memRdata | input | DATA_W | Bus read data, valid with memAck |
| rdBack | output | 4*DATA_W | Captured read-back words |

## Verification
The bench builds the block with ADDR_W=16, DATA_W=16 and BANK_SHIFT=12. With these values all four bank bases and both scaled command offsets fit in a readable 16-bit address. It sweeps every valid opcode across all four banks and both bus widths, with memory acknowledge latencies of 0, 1 and 2 cycles. Each logged bus cycle is compared against sequences worked out arithmetically. Bank and width inputs are changed during each run, and extra starts are issued while busy and with invalid opcodes, to show that they have no effect.

// File: rtl/flashCmdPkg.sv
package flashCmdPkg;

  localparam int RD_WORDS = 4;
  localparam int SLOT_W   = $clog2(RD_WORDS);

  localparam logic [2:0] OP_READ_ID = 3'd0;
  localparam logic [2:0] OP_TO_READ = 3'd1;
  localparam logic [2:0] OP_PROGRAM = 3'd2;
  localparam logic [2:0] OP_SECTOR  = 3'd3;
  localparam logic [2:0] OP_CHIP    = 3'd4;
  localparam logic [2:0] OP_QUERY   = 3'd5;

  typedef enum logic [1:0] {AK_BASE = 2'd0, AK_CMD = 2'd1, AK_USER = 2'd2} addrKindT;

  typedef struct packed {
    addrKindT            addrKind;
    logic [11:0]         cmdOff;
    logic [7:0]          cmdData;
    logic                useUser;
    logic                isRead;
    logic                isLast;
    logic [SLOT_W-1:0]   rdSlot;
  } stepT;

  typedef struct packed {
    logic                load;
    logic                active;
    logic                capture;
    addrKindT            addrKind;
    logic [11:0]         cmdOff;
    logic [7:0]          cmdData;
    logic                useUser;
    logic                isRead;
    logic [SLOT_W-1:0]   rdSlot;
  } ctlT;

  function automatic stepT cmdWrite(input logic [11:0] off, input logic [7:0] dat, input logic last);
    stepT s;
    s = '0;
    s.addrKind = AK_CMD;
    s.cmdOff   = off;
    s.cmdData  = dat;
    s.isLast   = last;
    return s;
  endfunction

  function automatic stepT cmdRead(input logic [11:0] off, input logic [SLOT_W-1:0] slot, input logic last);
    stepT s;
    s = '0;
    s.addrKind = AK_CMD;
    s.cmdOff   = off;
    s.isRead   = 1'b1;
    s.rdSlot   = slot;
    s.isLast   = last;
    return s;
  endfunction

  // Step table: what bus cycle number idx of operation op looks like.
  function automatic stepT stepInfo(input logic [2:0] op, input logic [2:0] idx);
    stepT s;
    logic prefixed;
    s = '0;
    prefixed = (op == OP_READ_ID) || (op == OP_PROGRAM) || (op == OP_SECTOR) || (op == OP_CHIP);
    if (prefixed && idx == 3'd0) begin
      s = cmdWrite(12'h555, 8'hAA, 1'b0);
    end else if (prefixed && idx == 3'd1) begin
      s = cmdWrite(12'h2AA, 8'h55, 1'b0);
    end else begin
      case (op)
        OP_READ_ID: begin
          case (idx)
            3'd2:    s = cmdWrite(12'h555, 8'h90, 1'b0);
            3'd3:    s = cmdRead(12'h000, 2'd0, 1'b0);
            3'd4:    s = cmdRead(12'h001, 2'd1, 1'b0);
            3'd5:    s = cmdRead(12'h00E, 2'd2, 1'b0);
            default: s = cmdRead(12'h00F, 2'd3, 1'b1);
          endcase
        end
        OP_TO_READ: begin
          s.addrKind = AK_BASE;
          s.cmdData  = 8'hF0;
          s.isLast   = 1'b1;
        end
        OP_PROGRAM: begin
          if (idx == 3'd2) s = cmdWrite(12'h555, 8'hA0, 1'b0);
          else begin
            s.addrKind = AK_USER;
            s.useUser  = 1'b1;
            s.isLast   = 1'b1;
          end
        end
        OP_SECTOR, OP_CHIP: begin
          case (idx)
            3'd2: s = cmdWrite(12'h555, 8'h80, 1'b0);
            3'd3: s = cmdWrite(12'h555, 8'hAA, 1'b0);
            3'd4: s = cmdWrite(12'h2AA, 8'h55, 1'b0);
            default: begin
              if (op == OP_CHIP) s = cmdWrite(12'h555, 8'h10, 1'b1);
              else begin
                s.addrKind = AK_USER;
                s.cmdData  = 8'h30;
                s.isLast   = 1'b1;
              end
            end
          endcase
        end
        OP_QUERY: begin
          if (idx == 3'd0) s = cmdWrite(12'h055, 8'h98, 1'b0);
          else s = cmdRead(12'h00F + {9'd0, idx}, SLOT_W'(idx - 3'd1), idx == 3'd4);
        end
        default: s = '0;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/flashCmdCtrl.sv
module flashCmdCtrl
  import flashCmdPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] reqOp,
  input  logic       reqStart,
  input  logic       memAck,
  output logic       busy,
  output logic       done,
  output logic       rejected,
  output ctlT        ctl
);

  logic [2:0] opReg;
  logic [2:0] stepIdx;
  logic       opValid;
  stepT       info;

  assign opValid = (reqOp <= OP_QUERY);
  assign info    = stepInfo(opReg, stepIdx);

  always_comb begin
    ctl          = '0;
    ctl.load     = !busy && reqStart && opValid;
    ctl.active   = busy;
    ctl.capture  = busy && memAck && info.isRead;
    ctl.addrKind = info.addrKind;
    ctl.cmdOff   = info.cmdOff;
    ctl.cmdData  = info.cmdData;
    ctl.useUser  = info.useUser;
    ctl.isRead   = info.isRead;
    ctl.rdSlot   = info.rdSlot;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      rejected <= 1'b0;
      opReg    <= '0;
      stepIdx  <= '0;
    end else begin
      done     <= 1'b0;
      rejected <= 1'b0;
      if (!busy) begin
        if (reqStart) begin
          if (opValid) begin
            busy    <= 1'b1;
            opReg   <= reqOp;
            stepIdx <= '0;
          end else begin
            rejected <= 1'b1;
          end
        end
      end else begin
        if (reqStart) rejected <= 1'b1;
        if (memAck) begin
          if (info.isLast) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            stepIdx <= stepIdx + 3'd1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/flashCmdPath.sv
module flashCmdPath
  import flashCmdPkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int DATA_W     = 16,
  parameter int BANK_SHIFT = 24
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqData,
  input  logic [1:0]               bankSel,
  input  logic                     busWide,
  input  ctlT                      ctl,
  input  logic [DATA_W-1:0]        memRdata,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [DATA_W-1:0]        memWdata,
  output logic                     memWe,
  output logic [RD_WORDS*DATA_W-1:0] rdBack
);

  logic [ADDR_W-1:0] userAddr;
  logic [DATA_W-1:0] userData;
  logic [1:0]        bankReg;
  logic              wideReg;
  logic [ADDR_W-1:0] baseAddr;
  logic [12:0]       offScaled;
  logic [ADDR_W-1:0] cmdAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      userAddr <= '0;
      userData <= '0;
      bankReg  <= '0;
      wideReg  <= 1'b0;
    end else if (ctl.load) begin
      userAddr <= reqAddr;
      userData <= reqData;
      bankReg  <= bankSel;
      wideReg  <= busWide;
    end
  end

  assign baseAddr  = ADDR_W'(bankReg) << BANK_SHIFT;
  assign offScaled = wideReg ? {ctl.cmdOff, 1'b0} : {1'b0, ctl.cmdOff};
  assign cmdAddr   = baseAddr + ADDR_W'(offScaled);

  always_comb begin
    case (ctl.addrKind)
      AK_CMD:  memAddr = cmdAddr;
      AK_USER: memAddr = userAddr;
      default: memAddr = baseAddr;
    endcase
  end

  assign memWdata = ctl.useUser ? userData : DATA_W'(ctl.cmdData);
  assign memWe    = ctl.active && !ctl.isRead;

  for (genvar s = 0; s < RD_WORDS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdBack[s*DATA_W +: DATA_W] <= '0;
      end else if (ctl.capture && ctl.rdSlot == SLOT_W'(s)) begin
        rdBack[s*DATA_W +: DATA_W] <= memRdata;
      end
    end
  end

endmodule

// File: rtl/flashCmdSeq.sv
module flashCmdSeq
  import flashCmdPkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int DATA_W     = 16,
  parameter int BANK_SHIFT = 24
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [2:0]                 reqOp,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic [DATA_W-1:0]          reqData,
  input  logic [1:0]                 bankSel,
  input  logic                       busWide,
  input  logic                       reqStart,
  output logic                       busy,
  output logic                       done,
  output logic                       rejected,
  output logic                       memReq,
  output logic                       memWe,
  output logic [ADDR_W-1:0]          memAddr,
  output logic [DATA_W-1:0]          memWdata,
  input  logic                       memAck,
  input  logic [DATA_W-1:0]          memRdata,
  output logic [RD_WORDS*DATA_W-1:0] rdBack
);

  ctlT ctl;

  flashCmdCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqOp    (reqOp),
    .reqStart (reqStart),
    .memAck   (memAck),
    .busy     (busy),
    .done     (done),
    .rejected (rejected),
    .ctl      (ctl)
  );

  flashCmdPath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .BANK_SHIFT (BANK_SHIFT)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .bankSel  (bankSel),
    .busWide  (busWide),
    .ctl      (ctl),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe),
    .rdBack   (rdBack)
  );

  assign memReq = busy;

endmodule

// File: rtl/flashCmdSeqChecker.sv
module flashCmdSeqChecker #(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqStart,
  input logic              busy,
  input logic              done,
  input logic              rejected,
  input logic              memReq,
  input logic              memAck,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata
);

  a_r9_reject_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy && reqStart |=> rejected);

  a_r9_busy_needs_ack: assert property (@(posedge clk) disable iff (!rstN)
    busy && !memAck |=> busy);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r10_done_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(memReq && memAck));

  a_r11_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWdata) && $stable(memWe));

endmodule

bind flashCmdSeq flashCmdSeqChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqStart (reqStart),
  .busy     (busy),
  .done     (done),
  .rejected (rejected),
  .memReq   (memReq),
  .memAck   (memAck),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memWdata (memWdata)
);

// File: tb/flashCmdSeq_bench.sv
`timescale 1ns/100ps
module flashCmdSeq_bench;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int BSH    = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [2:0]        reqOp = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqData = '0;
  logic [1:0]        bankSel = '0;
  logic              busWide = 1'b0;
  logic              reqStart = 1'b0;
  logic              busy, done, rejected, memReq, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic              memAck = 1'b0;
  logic [DATA_W-1:0] memRdata = '0;
  logic [4*DATA_W-1:0] rdBack;

  always #2.5 clk = ~clk;

  flashCmdSeq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_SHIFT(BSH)) u_flashCmdSeq (
    .clk(clk), .rstN(rstN), .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData),
    .bankSel(bankSel), .busWide(busWide), .reqStart(reqStart), .busy(busy),
    .done(done), .rejected(rejected), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata),
    .rdBack(rdBack));

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory responder and bus logger
  int  cyc = 0, lat = 0, waitCnt = 0;
  int  logN = 0, lastAckCyc = 0, doneCyc = 0, doneCount = 0;
  bit  busyAtDone = 0, stableErr = 0;
  bit  logWe[16];
  int  logAddr[16], logData[16];
  int  heldAddr = 0, heldData = 0;

  always @(negedge clk) begin
    cyc++;
    if (done) begin
      doneCyc = cyc;
      busyAtDone = busy;
      doneCount++;
    end
    if (memReq) begin
      if (waitCnt == 0) begin
        heldAddr = int'(memAddr);
        heldData = int'(memWdata);
      end else if (heldAddr != int'(memAddr) || (memWe && heldData != int'(memWdata))) begin
        stableErr = 1;
      end
      if (waitCnt == lat) begin
        memAck = 1'b1;
        memRdata = memAddr ^ 16'h5A00;
        if (logN < 16) begin
          logWe[logN] = memWe;
          logAddr[logN] = int'(memAddr);
          logData[logN] = int'(memWdata);
        end
        logN++;
        lastAckCyc = cyc;
        waitCnt = 0;
      end else begin
        memAck = 1'b0;
        waitCnt++;
      end
    end else begin
      memAck = 1'b0;
      waitCnt = 0;
    end
  end

  // Expected sequences
  bit expWe[16];
  int expAddr[16], expData[16];
  int expN;

  function automatic int cmdA(input int off, input int bank, input bit wide);
    return (bank << BSH) + (wide ? off * 2 : off);
  endfunction

  function automatic void push(input bit we, input int a, input int d);
    expWe[expN] = we; expAddr[expN] = a; expData[expN] = d; expN++;
  endfunction

  function automatic void buildExp(input int op, input int bank, input bit wide, input int ua, input int ud);
    expN = 0;
    if (op == 0 || op == 2 || op == 3 || op == 4) begin
      push(1, cmdA(12'h555, bank, wide), 8'hAA);
      push(1, cmdA(12'h2AA, bank, wide), 8'h55);
    end
    case (op)
      0: begin
        push(1, cmdA(12'h555, bank, wide), 8'h90);
        push(0, cmdA(0, bank, wide), 0);
        push(0, cmdA(1, bank, wide), 0);
        push(0, cmdA(14, bank, wide), 0);
        push(0, cmdA(15, bank, wide), 0);
      end
      1: push(1, bank << BSH, 8'hF0);
      2: begin
        push(1, cmdA(12'h555, bank, wide), 8'hA0);
        push(1, ua, ud);
      end
      3, 4: begin
        push(1, cmdA(12'h555, bank, wide), 8'h80);
        push(1, cmdA(12'h555, bank, wide), 8'hAA);
        push(1, cmdA(12'h2AA, bank, wide), 8'h55);
        if (op == 3) push(1, ua, 8'h30);
        else push(1, cmdA(12'h555, bank, wide), 8'h10);
      end
      default: begin
        push(1, cmdA(12'h055, bank, wide), 8'h98);
        for (int k = 0; k < 4; k++) push(0, cmdA(16 + k, bank, wide), 0);
      end
    endcase
  endfunction

  function automatic string reqOf(input int op);
    case (op)
      0: return "R2";
      1: return "R7";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic runOp(input int op, input int bank, input bit wide, input int l,
                       input int ua, input int ud, input bit poke);
    int startDone;
    int bad;
    int firstBad;
    string rq;
    rq = reqOf(op);
    buildExp(op, bank, wide, ua, ud);
    @(negedge clk); #1;
    lat = l; logN = 0; stableErr = 0; startDone = doneCount;
    reqOp = 3'(op); bankSel = 2'(bank); busWide = wide;
    reqAddr = 16'(ua); reqData = 16'(ud); reqStart = 1'b1;
    @(negedge clk); #1;
    reqStart = 1'b0;
    chk(busy == 1'b1, "R9", "busy after start", busy, 1);
    // R8: inputs changed after acceptance must not matter
    bankSel = ~bankSel; busWide = ~busWide;
    if (poke) begin
      reqOp = 3'd4; reqStart = 1'b1;
      @(negedge clk); #1;
      reqStart = 1'b0;
      chk(rejected == 1'b1, "R9", "reject while busy", rejected, 1);
    end
    for (int t = 0; t < 200 && doneCount == startDone; t++) begin
      @(negedge clk); #1;
    end
    bad = 0; firstBad = -1;
    if (logN != expN) bad++;
    for (int k = 0; k < expN && k < logN; k++) begin
      if (logWe[k] != expWe[k] || logAddr[k] != expAddr[k] || (expWe[k] && logData[k] != expData[k])) begin
        bad++;
        if (firstBad < 0) firstBad = k;
      end
    end
    chk(bad == 0, rq, $sformatf("sequence op%0d bank%0d wide%0d step%0d count", op, bank, wide, firstBad),
        logN, expN);
    if (op == 0 || op == 2 || op == 3 || op == 4)
      chk(logN >= 2 && logAddr[0] == cmdA(12'h555, bank, wide) && logData[0] == 8'hAA &&
          logAddr[1] == cmdA(12'h2AA, bank, wide) && logData[1] == 8'h55, "R1", "unlock prefix",
          logAddr[0], cmdA(12'h555, bank, wide));
    if (wide) chk(bad == 0, "R8", "scaled command address", logAddr[0], expAddr[0]);
    chk(doneCyc == lastAckCyc + 1 && !busyAtDone, "R10", "done timing", doneCyc, lastAckCyc + 1);
    chk(!stableErr, "R11", "held request until ack", stableErr, 0);
    if (op == 0 || op == 5) begin
      for (int k = 0; k < 4; k++) begin
        int e;
        e = expAddr[expN - 4 + k] ^ 16'h5A00;
        chk(int'(rdBack[k*DATA_W +: DATA_W]) == e, rq, $sformatf("read-back slot %0d", k),
            rdBack[k*DATA_W +: DATA_W], e);
      end
    end
    @(negedge clk); #1;
    chk(done == 1'b0 && busy == 1'b0, "R10", "done single pulse", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    chk(!busy && !done && !rejected && !memReq, "R9", "reset state", {busy, done, rejected, memReq}, 0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(!busy && !memReq, "R11", "idle after reset", memReq, 0);

    for (int op = 0; op < 6; op++)
      for (int bank = 0; bank < 4; bank++)
        for (int w = 0; w < 2; w++)
          runOp(op, bank, w[0], (bank + w) % 3, 16'h0F00 + op * 16'h0123 + bank * 16'h1000,
                16'h1357 * (op + bank + w + 1) & 16'hFFFF, 1'b0);

    // start while busy: program continues unchanged (R9)
    runOp(2, 1, 1'b1, 2, 16'h2468, 16'hBEEF, 1'b1);
    runOp(3, 2, 1'b0, 1, 16'h3000, 16'h0000, 1'b1);

    // invalid opcodes are refused (R9)
    for (int bad = 6; bad < 8; bad++) begin
      @(negedge clk); #1;
      reqOp = 3'(bad); reqStart = 1'b1;
      @(negedge clk); #1;
      reqStart = 1'b0;
      chk(rejected && !busy && !memReq, "R9", $sformatf("opcode %0d refused", bad),
          {rejected, busy, memReq}, 3'b100);
      @(negedge clk); #1;
      chk(!rejected && !busy, "R9", "reject single pulse", rejected, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule